// File: doc/BRIEF.md
# System Register Access Trap Decoder

This block judges one read of a virtualisable interrupt-controller status register, the register that reports the highest-priority pending Group 1 interrupt. The inputs are the current exception level, feature-present flags, the execution-state width of the hypervisor and monitor levels, whether the core sits in monitor mode, and the control bits from the hypervisor and secure-monitor configuration. From these it picks exactly one of five outcomes: undefined instruction, trap to the hypervisor with a syndrome class, trap to the monitor, read of the virtual copy, or read of the physical copy.

For the two read outcomes the block also returns the 32-bit read data. The data comes from the pending-interrupt ID of the selected copy. It is masked to the implemented ID width, and the special value 1023 is returned when no interrupt can be observed. The decision is a strict priority chain, and its order depends on the exception level. The result is captured in an output register one cycle after the request strobe. Exception entry, interrupt prioritisation and the register storage itself sit outside this block.

Top module: `sysreg_trap_decoder`

## Requirements
- R1: When `feat_aa32_kern` or `feat_ic_v3` is 0, or `cur_level` is 0 (user level), the outcome is undefined. Levels are encoded 0 user, 1 kernel, 2 hypervisor, 3 monitor.
- R2: At kernel level the outcome is undefined, ahead of every other kernel check, when all of the following hold: the monitor is present, `mon_early_undef` is 1, and the monitor's IRQ-routing bit is 1. That routing bit is `mon_irq_route_a32` when `mon_is_aa32` is 1 and `mon_irq_route_a64` otherwise. With a 32-bit monitor this check is skipped while `in_mon_mode` is 1.
- R3: At kernel level, next in order: when `hyp_enabled` is 1 and the group-12 trap bit of the hypervisor's form is set, the access traps to the hypervisor. The form is `_a32` when `hyp_is_aa32` is 1 and `_a64` otherwise. The syndrome output then carries 0x03.
- R4: At kernel level, next in order, `sre_kern` = 0 gives undefined.
- R5: At kernel level, next in order: when `hyp_enabled` is 1 and the trap-all-Group-1 bit of the hypervisor's form is set, the access traps to the hypervisor with syndrome 0x03.
- R6: At kernel level, next in order: when `hyp_enabled` is 1 and the IRQ-virtualisation bit of the hypervisor's form is set, the outcome is a read of the virtual copy.
- R7: At kernel level, last: when the monitor is present and its routing bit is set (the same form choice and monitor-mode exception as R2), the outcome is undefined if `mon_undef_sel` is 1 and a monitor trap otherwise. If no check fires, the outcome is a read of the physical copy.
- R8: At hypervisor level the checks run in this order. First, monitor present with `mon_early_undef` and its routing bit set gives undefined. Then `sre_hyp` = 0 gives undefined. Then monitor present with its routing bit set gives undefined if `mon_undef_sel` is 1 and a monitor trap otherwise. If none fires, the outcome is a read of the physical copy. The monitor-mode exception does not apply at this level.
- R9: At monitor level, `sre_mon` = 0 gives undefined; otherwise the outcome is a read of the physical copy.
- R10: For a read, `res_rdata` carries the selected copy's ID. With `id_wide` = 1 it carries bits 23:0. With `id_wide` = 0 it carries bits 15:0, and bits 23:16 are 0. Bits 31:24 are always 0.
- R11: When the selected copy's valid input is 0, the ID field reads 1023.
- R12: When `rsp_valid` is 1, exactly one outcome line is 1. When `rsp_valid` is 0, all outcome lines are 0. `res_syndrome` is 0 except on a hypervisor trap. `res_rdata` is 0 except on a read.
- R13: All results appear one cycle after the request strobe. `rsp_valid` copies the strobe of the previous cycle, and after reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe for one access |
| cur_level | input | 2 | Current exception level (0 user, 1 kernel, 2 hypervisor, 3 monitor) |
| feat_aa32_kern | input | 1 | 32-bit kernel-level execution state implemented |
| feat_ic_v3 | input | 1 | System-register interrupt-controller interface implemented |
| hyp_enabled | input | 1 | Hypervisor level present and enabled in the current state |
| hyp_is_aa32 | input | 1 | Hypervisor runs in 32-bit state |
| mon_present | input | 1 | Monitor level present |
| mon_is_aa32 | input | 1 | Monitor runs in 32-bit state |
| in_mon_mode | input | 1 | Core is currently in 32-bit monitor mode |
| mon_early_undef | input | 1 | Monitor option: undefined takes priority over traps |
| mon_undef_sel | input | 1 | Monitor option: routed accesses become undefined instead of trapping |
| mon_irq_route_a64 | input | 1 | IRQ-routing bit, 64-bit monitor form |
| mon_irq_route_a32 | input | 1 | IRQ-routing bit, 32-bit monitor form |
| hyp_g12_trap_a64 | input | 1 | Group-12 register trap bit, 64-bit hypervisor form |
| hyp_g12_trap_a32 | input | 1 | Group-12 register trap bit, 32-bit hypervisor form |
| hyp_trap_grp1_a64 | input | 1 | Trap-all-Group-1 bit, 64-bit hypervisor form |
| hyp_trap_grp1_a32 | input | 1 | Trap-all-Group-1 bit, 32-bit hypervisor form |
| hyp_virq_a64 | input | 1 | IRQ-virtualisation bit, 64-bit hypervisor form |
| hyp_virq_a32 | input | 1 | IRQ-virtualisation bit, 32-bit hypervisor form |
| sre_kern | input | 1 | System-register enable, kernel level |
| sre_hyp | input | 1 | System-register enable, hypervisor level |
| sre_mon | input | 1 | System-register enable, monitor level |
| id_wide | input | 1 | 1: 24-bit IDs, 0: 16-bit IDs |
| virt_pend_vld | input | 1 | Virtual copy has an observable pending interrupt |
| virt_pend_id | input | 24 | Virtual copy pending interrupt ID |
| phys_pend_vld | input | 1 | Physical copy has an observable pending interrupt |
| phys_pend_id | input | 24 | Physical copy pending interrupt ID |
| rsp_valid | output | 1 | Result valid |
| res_undef | output | 1 | Outcome: undefined instruction |
| res_trap_hyp | output | 1 | Outcome: trap to hypervisor |
| res_trap_mon | output | 1 | Outcome: trap to monitor |
| res_rd_virt | output | 1 | Outcome: read virtual copy |
| res_rd_phys | output | 1 | Outcome: read physical copy |
| res_syndrome | output | 8 | Syndrome class, valid on hypervisor trap |
| res_rdata | output | 32 | Read data |

## Verification
The block holds state only in its output register. A wrong decision therefore shows at the outcome ports in the cycle right after the strobe, as a wrong or doubled outcome line. A check out of order shows only when two rules fire together: for example, a trap reported where an earlier undefined should have won. Control bits are varied pseudo-randomly across all levels and both execution-state forms, so these collisions come up often. A slip in masking or in the special-ID substitution shows in the same cycle as a wrong high bit or a wrong low field of `res_rdata`.

// File: rtl/trapdec_pkg.sv
package trapdec_pkg;

    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_KERN = 2'd1,
        LVL_HYP  = 2'd2,
        LVL_MON  = 2'd3
    } level_e;

    localparam int OC_N      = 5;
    localparam int OC_UNDEF  = 0;
    localparam int OC_HYP    = 1;
    localparam int OC_MON    = 2;
    localparam int OC_VIRT   = 3;
    localparam int OC_PHYS   = 4;

    typedef logic [OC_N-1:0] outcome_t;

    localparam outcome_t ONE_UNDEF = outcome_t'(1 << OC_UNDEF);
    localparam outcome_t ONE_HYP   = outcome_t'(1 << OC_HYP);
    localparam outcome_t ONE_MON   = outcome_t'(1 << OC_MON);
    localparam outcome_t ONE_VIRT  = outcome_t'(1 << OC_VIRT);
    localparam outcome_t ONE_PHYS  = outcome_t'(1 << OC_PHYS);

    // Control bits after the 64/32-bit form selection, as seen by the
    // kernel-level chain.
    typedef struct packed {
        logic mon_fire;     // monitor present, routing set, mode exception applied
        logic early_undef;
        logic undef_sel;
        logic g12_trap;     // hypervisor enabled and group-12 trap set
        logic grp1_trap;    // hypervisor enabled and trap-all-Group-1 set
        logic virq;         // hypervisor enabled and IRQ virtualisation set
    } kctl_t;

endpackage

// File: rtl/trapdec_form_sel.sv
module trapdec_form_sel
    import trapdec_pkg::*;
(
    input  logic  hyp_enabled,
    input  logic  hyp_is_aa32,
    input  logic  mon_present,
    input  logic  mon_is_aa32,
    input  logic  in_mon_mode,
    input  logic  mon_early_undef,
    input  logic  mon_undef_sel,
    input  logic  mon_irq_route_a64,
    input  logic  mon_irq_route_a32,
    input  logic  hyp_g12_trap_a64,
    input  logic  hyp_g12_trap_a32,
    input  logic  hyp_trap_grp1_a64,
    input  logic  hyp_trap_grp1_a32,
    input  logic  hyp_virq_a64,
    input  logic  hyp_virq_a32,
    output kctl_t kctl,
    output logic  mon_fire_hl
);

    logic route_sel;
    logic mode_ok;

    always_comb begin
        route_sel = mon_is_aa32 ? mon_irq_route_a32 : mon_irq_route_a64;
        // A 32-bit monitor exempts accesses made from monitor mode itself.
        mode_ok   = !mon_is_aa32 || !in_mon_mode;

        kctl.mon_fire    = mon_present && route_sel && mode_ok;
        kctl.early_undef = mon_early_undef;
        kctl.undef_sel   = mon_undef_sel;
        kctl.g12_trap    = hyp_enabled &&
                           (hyp_is_aa32 ? hyp_g12_trap_a32 : hyp_g12_trap_a64);
        kctl.grp1_trap   = hyp_enabled &&
                           (hyp_is_aa32 ? hyp_trap_grp1_a32 : hyp_trap_grp1_a64);
        kctl.virq        = hyp_enabled &&
                           (hyp_is_aa32 ? hyp_virq_a32 : hyp_virq_a64);

        // Hypervisor-level accesses see the routing bit without the mode exception.
        mon_fire_hl      = mon_present && route_sel;
    end

endmodule

// File: rtl/trapdec_kern_chain.sv
module trapdec_kern_chain
    import trapdec_pkg::*;
(
    input  kctl_t    kctl,
    input  logic     sre_kern,
    output outcome_t oc
);

    always_comb begin
        if (kctl.mon_fire && kctl.early_undef) begin
            oc = ONE_UNDEF;
        end else if (kctl.g12_trap) begin
            oc = ONE_HYP;
        end else if (!sre_kern) begin
            oc = ONE_UNDEF;
        end else if (kctl.grp1_trap) begin
            oc = ONE_HYP;
        end else if (kctl.virq) begin
            oc = ONE_VIRT;
        end else if (kctl.mon_fire) begin
            oc = kctl.undef_sel ? ONE_UNDEF : ONE_MON;
        end else begin
            oc = ONE_PHYS;
        end
    end

endmodule

// File: rtl/trapdec_upper_chain.sv
module trapdec_upper_chain
    import trapdec_pkg::*;
(
    input  logic     at_mon_level,
    input  logic     mon_fire_hl,
    input  logic     early_undef,
    input  logic     undef_sel,
    input  logic     sre_hyp,
    input  logic     sre_mon,
    output outcome_t oc
);

    outcome_t hyp_oc;
    outcome_t mon_oc;

    always_comb begin
        if (mon_fire_hl && early_undef) begin
            hyp_oc = ONE_UNDEF;
        end else if (!sre_hyp) begin
            hyp_oc = ONE_UNDEF;
        end else if (mon_fire_hl) begin
            hyp_oc = undef_sel ? ONE_UNDEF : ONE_MON;
        end else begin
            hyp_oc = ONE_PHYS;
        end

        mon_oc = sre_mon ? ONE_PHYS : ONE_UNDEF;
        oc     = at_mon_level ? mon_oc : hyp_oc;
    end

endmodule

// File: rtl/trapdec_id_fmt.sv
module trapdec_id_fmt #(
    parameter int DATA_W     = 32,
    parameter int ID_W       = 24,
    parameter int ID_NARROW  = 16,
    parameter int SPECIAL_ID = 1023
) (
    input  logic              id_wide,
    input  logic              pend_vld,
    input  logic [ID_W-1:0]   pend_id,
    output logic [DATA_W-1:0] data
);

    logic [ID_W-1:0] src;

    always_comb begin
        src = pend_vld ? pend_id : ID_W'(SPECIAL_ID);
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b < ID_NARROW) begin : g_low
            assign data[b] = src[b];
        end else if (b < ID_W) begin : g_mid
            assign data[b] = id_wide & src[b];
        end else begin : g_top
            assign data[b] = 1'b0;
        end
    end

endmodule

// File: rtl/sysreg_trap_decoder.sv
module sysreg_trap_decoder
    import trapdec_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ID_W       = 24,
    parameter int ID_NARROW  = 16,
    parameter int SPECIAL_ID = 1023,
    parameter int SYN_W      = 8,
    parameter int HYP_EC     = 3,
    parameter bit REG_OUT    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        cur_level,
    input  logic              feat_aa32_kern,
    input  logic              feat_ic_v3,
    input  logic              hyp_enabled,
    input  logic              hyp_is_aa32,
    input  logic              mon_present,
    input  logic              mon_is_aa32,
    input  logic              in_mon_mode,
    input  logic              mon_early_undef,
    input  logic              mon_undef_sel,
    input  logic              mon_irq_route_a64,
    input  logic              mon_irq_route_a32,
    input  logic              hyp_g12_trap_a64,
    input  logic              hyp_g12_trap_a32,
    input  logic              hyp_trap_grp1_a64,
    input  logic              hyp_trap_grp1_a32,
    input  logic              hyp_virq_a64,
    input  logic              hyp_virq_a32,
    input  logic              sre_kern,
    input  logic              sre_hyp,
    input  logic              sre_mon,
    input  logic              id_wide,
    input  logic              virt_pend_vld,
    input  logic [ID_W-1:0]   virt_pend_id,
    input  logic              phys_pend_vld,
    input  logic [ID_W-1:0]   phys_pend_id,
    output logic              rsp_valid,
    output logic              res_undef,
    output logic              res_trap_hyp,
    output logic              res_trap_mon,
    output logic              res_rd_virt,
    output logic              res_rd_phys,
    output logic [SYN_W-1:0]  res_syndrome,
    output logic [DATA_W-1:0] res_rdata
);

    localparam int N_COPY = 2;
    localparam int C_VIRT = 0;
    localparam int C_PHYS = 1;
    localparam logic [SYN_W-1:0] EC_VAL = SYN_W'(HYP_EC);

    typedef struct packed {
        logic              valid;
        outcome_t          oc;
        logic [SYN_W-1:0]  syn;
        logic [DATA_W-1:0] data;
    } rsp_t;

    kctl_t    kctl;
    logic     mon_fire_hl;
    outcome_t kern_oc;
    outcome_t upper_oc;
    level_e   lvl;
    rsp_t     rsp_d;
    rsp_t     rsp_q;

    logic              copy_vld  [N_COPY];
    logic [ID_W-1:0]   copy_id   [N_COPY];
    logic [DATA_W-1:0] copy_data [N_COPY];

    assign lvl = level_e'(cur_level);

    trapdec_form_sel u_form (
        .hyp_enabled       (hyp_enabled),
        .hyp_is_aa32       (hyp_is_aa32),
        .mon_present       (mon_present),
        .mon_is_aa32       (mon_is_aa32),
        .in_mon_mode       (in_mon_mode),
        .mon_early_undef   (mon_early_undef),
        .mon_undef_sel     (mon_undef_sel),
        .mon_irq_route_a64 (mon_irq_route_a64),
        .mon_irq_route_a32 (mon_irq_route_a32),
        .hyp_g12_trap_a64  (hyp_g12_trap_a64),
        .hyp_g12_trap_a32  (hyp_g12_trap_a32),
        .hyp_trap_grp1_a64 (hyp_trap_grp1_a64),
        .hyp_trap_grp1_a32 (hyp_trap_grp1_a32),
        .hyp_virq_a64      (hyp_virq_a64),
        .hyp_virq_a32      (hyp_virq_a32),
        .kctl              (kctl),
        .mon_fire_hl       (mon_fire_hl)
    );

    trapdec_kern_chain u_kern (
        .kctl     (kctl),
        .sre_kern (sre_kern),
        .oc       (kern_oc)
    );

    trapdec_upper_chain u_upper (
        .at_mon_level (lvl == LVL_MON),
        .mon_fire_hl  (mon_fire_hl),
        .early_undef  (mon_early_undef),
        .undef_sel    (mon_undef_sel),
        .sre_hyp      (sre_hyp),
        .sre_mon      (sre_mon),
        .oc           (upper_oc)
    );

    assign copy_vld[C_VIRT] = virt_pend_vld;
    assign copy_id[C_VIRT]  = virt_pend_id;
    assign copy_vld[C_PHYS] = phys_pend_vld;
    assign copy_id[C_PHYS]  = phys_pend_id;

    for (genvar c = 0; c < N_COPY; c++) begin : g_copy
        trapdec_id_fmt #(
            .DATA_W     (DATA_W),
            .ID_W       (ID_W),
            .ID_NARROW  (ID_NARROW),
            .SPECIAL_ID (SPECIAL_ID)
        ) u_fmt (
            .id_wide  (id_wide),
            .pend_vld (copy_vld[c]),
            .pend_id  (copy_id[c]),
            .data     (copy_data[c])
        );
    end

    always_comb begin
        rsp_d = '0;
        if (req) begin
            rsp_d.valid = 1'b1;
            if (!(feat_aa32_kern && feat_ic_v3) || lvl == LVL_USER) begin
                rsp_d.oc = ONE_UNDEF;
            end else if (lvl == LVL_KERN) begin
                rsp_d.oc = kern_oc;
            end else begin
                rsp_d.oc = upper_oc;
            end
            if (rsp_d.oc[OC_HYP]) begin
                rsp_d.syn = EC_VAL;
            end
            if (rsp_d.oc[OC_VIRT]) begin
                rsp_d.data = copy_data[C_VIRT];
            end else if (rsp_d.oc[OC_PHYS]) begin
                rsp_d.data = copy_data[C_PHYS];
            end
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rsp_q <= '0;
            end else begin
                rsp_q <= rsp_d;
            end
        end

        p_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid == $past(req));

        p_user_undef_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (req && cur_level == 2'd0) |=> (res_undef && rsp_valid));

        p_mon_phys_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (req && cur_level == 2'd3 && feat_aa32_kern && feat_ic_v3 && sre_mon)
            |=> res_rd_phys);
    end else begin : g_comb
        assign rsp_q = rsp_d;
    end

    assign rsp_valid    = rsp_q.valid;
    assign res_undef    = rsp_q.oc[OC_UNDEF];
    assign res_trap_hyp = rsp_q.oc[OC_HYP];
    assign res_trap_mon = rsp_q.oc[OC_MON];
    assign res_rd_virt  = rsp_q.oc[OC_VIRT];
    assign res_rd_phys  = rsp_q.oc[OC_PHYS];
    assign res_syndrome = rsp_q.syn;
    assign res_rdata    = rsp_q.data;

    p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({res_undef, res_trap_hyp, res_trap_mon,
                                  res_rd_virt, res_rd_phys}) == 1);

    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(res_undef || res_trap_hyp || res_trap_mon ||
                         res_rd_virt || res_rd_phys));

    p_syn_hyp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_trap_hyp |-> res_syndrome == EC_VAL);

    p_syn_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !res_trap_hyp |-> res_syndrome == '0);

    p_data_nonread_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_rd_virt || res_rd_phys) |-> res_rdata == '0);

    p_top_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_rdata[DATA_W-1:ID_W] == '0);

endmodule

// File: tb/sysreg_trap_decoder_tb_top.sv
module sysreg_trap_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 30000;

    localparam int E_UNDEF = 0;
    localparam int E_HYP   = 1;
    localparam int E_MON   = 2;
    localparam int E_VIRT  = 3;
    localparam int E_PHYS  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  cur_level = 2'd0;
    logic        feat_aa32_kern = 1'b0, feat_ic_v3 = 1'b0;
    logic        hyp_enabled = 1'b0, hyp_is_aa32 = 1'b0;
    logic        mon_present = 1'b0, mon_is_aa32 = 1'b0, in_mon_mode = 1'b0;
    logic        mon_early_undef = 1'b0, mon_undef_sel = 1'b0;
    logic        mon_irq_route_a64 = 1'b0, mon_irq_route_a32 = 1'b0;
    logic        hyp_g12_trap_a64 = 1'b0, hyp_g12_trap_a32 = 1'b0;
    logic        hyp_trap_grp1_a64 = 1'b0, hyp_trap_grp1_a32 = 1'b0;
    logic        hyp_virq_a64 = 1'b0, hyp_virq_a32 = 1'b0;
    logic        sre_kern = 1'b0, sre_hyp = 1'b0, sre_mon = 1'b0;
    logic        id_wide = 1'b0;
    logic        virt_pend_vld = 1'b0, phys_pend_vld = 1'b0;
    logic [23:0] virt_pend_id = '0, phys_pend_id = '0;

    logic        rsp_valid, res_undef, res_trap_hyp, res_trap_mon;
    logic        res_rd_virt, res_rd_phys;
    logic [7:0]  res_syndrome;
    logic [31:0] res_rdata;

    int checks = 0;
    int errors = 0;
    int unsigned seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysreg_trap_decoder dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .req               (req),
        .cur_level         (cur_level),
        .feat_aa32_kern    (feat_aa32_kern),
        .feat_ic_v3        (feat_ic_v3),
        .hyp_enabled       (hyp_enabled),
        .hyp_is_aa32       (hyp_is_aa32),
        .mon_present       (mon_present),
        .mon_is_aa32       (mon_is_aa32),
        .in_mon_mode       (in_mon_mode),
        .mon_early_undef   (mon_early_undef),
        .mon_undef_sel     (mon_undef_sel),
        .mon_irq_route_a64 (mon_irq_route_a64),
        .mon_irq_route_a32 (mon_irq_route_a32),
        .hyp_g12_trap_a64  (hyp_g12_trap_a64),
        .hyp_g12_trap_a32  (hyp_g12_trap_a32),
        .hyp_trap_grp1_a64 (hyp_trap_grp1_a64),
        .hyp_trap_grp1_a32 (hyp_trap_grp1_a32),
        .hyp_virq_a64      (hyp_virq_a64),
        .hyp_virq_a32      (hyp_virq_a32),
        .sre_kern          (sre_kern),
        .sre_hyp           (sre_hyp),
        .sre_mon           (sre_mon),
        .id_wide           (id_wide),
        .virt_pend_vld     (virt_pend_vld),
        .virt_pend_id      (virt_pend_id),
        .phys_pend_vld     (phys_pend_vld),
        .phys_pend_id      (phys_pend_id),
        .rsp_valid         (rsp_valid),
        .res_undef         (res_undef),
        .res_trap_hyp      (res_trap_hyp),
        .res_trap_mon      (res_trap_mon),
        .res_rd_virt       (res_rd_virt),
        .res_rd_phys       (res_rd_phys),
        .res_syndrome      (res_syndrome),
        .res_rdata         (res_rdata)
    );

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: nested decision chain straight from the requirements.
    function automatic int ref_outcome(output string tag);
        bit route, mode_ok, g12, grp1, virq;
        route   = mon_is_aa32 ? mon_irq_route_a32 : mon_irq_route_a64;
        mode_ok = !(mon_is_aa32 && in_mon_mode);
        g12     = hyp_is_aa32 ? hyp_g12_trap_a32 : hyp_g12_trap_a64;
        grp1    = hyp_is_aa32 ? hyp_trap_grp1_a32 : hyp_trap_grp1_a64;
        virq    = hyp_is_aa32 ? hyp_virq_a32 : hyp_virq_a64;
        if (!feat_aa32_kern || !feat_ic_v3 || cur_level == 2'd0) begin
            tag = "R1"; return E_UNDEF;
        end
        if (cur_level == 2'd1) begin
            if (mon_present && mon_early_undef && route && mode_ok) begin
                tag = "R2"; return E_UNDEF;
            end
            if (hyp_enabled && g12) begin tag = "R3"; return E_HYP; end
            if (!sre_kern) begin tag = "R4"; return E_UNDEF; end
            if (hyp_enabled && grp1) begin tag = "R5"; return E_HYP; end
            if (hyp_enabled && virq) begin tag = "R6"; return E_VIRT; end
            tag = "R7";
            if (mon_present && route && mode_ok)
                return mon_undef_sel ? E_UNDEF : E_MON;
            return E_PHYS;
        end
        if (cur_level == 2'd2) begin
            tag = "R8";
            if (mon_present && mon_early_undef && route) return E_UNDEF;
            if (!sre_hyp) return E_UNDEF;
            if (mon_present && route) return mon_undef_sel ? E_UNDEF : E_MON;
            return E_PHYS;
        end
        tag = "R9";
        return sre_mon ? E_PHYS : E_UNDEF;
    endfunction

    function automatic logic [31:0] ref_fmt(input bit vld, input logic [23:0] id);
        logic [23:0] s;
        s = vld ? id : 24'd1023;
        return id_wide ? {8'h00, s} : {16'h0000, s[15:0]};
    endfunction

    // Drive is already set by the caller at a falling edge; the result is
    // registered at the next rising edge and sampled at the falling edge after.
    task automatic issue();
        string tag, dtag;
        int    e;
        logic [4:0]  exp_oc;
        logic [7:0]  exp_syn;
        logic [31:0] exp_data;
        e = ref_outcome(tag);
        exp_oc   = req ? 5'(1 << e) : 5'b0;
        exp_syn  = (req && e == E_HYP) ? 8'h03 : 8'h00;
        exp_data = 32'h0;
        dtag     = "R12";
        if (req && e == E_VIRT) begin
            exp_data = ref_fmt(virt_pend_vld, virt_pend_id);
            dtag = virt_pend_vld ? "R10" : "R11";
        end else if (req && e == E_PHYS) begin
            exp_data = ref_fmt(phys_pend_vld, phys_pend_id);
            dtag = phys_pend_vld ? "R10" : "R11";
        end
        if (!req) tag = "R12";
        @(negedge clk);
        check("R13", "rsp_valid", rsp_valid, req);
        check(tag, "outcome", {res_rd_phys, res_rd_virt, res_trap_mon,
                               res_trap_hyp, res_undef}, exp_oc);
        check(req && e == E_HYP ? "R3" : "R12", "syndrome", res_syndrome, exp_syn);
        check(dtag, "rdata", res_rdata, exp_data);
    endtask

    task automatic clear_ctl();
        {feat_aa32_kern, feat_ic_v3} = 2'b11;
        {hyp_enabled, hyp_is_aa32, mon_present, mon_is_aa32, in_mon_mode} = '0;
        {mon_early_undef, mon_undef_sel, mon_irq_route_a64, mon_irq_route_a32} = '0;
        {hyp_g12_trap_a64, hyp_g12_trap_a32, hyp_trap_grp1_a64, hyp_trap_grp1_a32} = '0;
        {hyp_virq_a64, hyp_virq_a32} = '0;
        {sre_kern, sre_hyp, sre_mon} = 3'b111;
        id_wide = 1'b1;
        virt_pend_vld = 1'b1; virt_pend_id = 24'hA5_1234;
        phys_pend_vld = 1'b1; phys_pend_id = 24'h5A_4321;
        req = 1'b1;
    endtask

    function automatic int unsigned next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL R13 watchdog actual=timeout expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R13", "reset rsp_valid", rsp_valid, 0);
        check("R12", "reset outcome", {res_rd_phys, res_rd_virt, res_trap_mon,
                                       res_trap_hyp, res_undef}, 0);
        check("R12", "reset rdata", res_rdata, 0);
        rst_n = 1'b1;

        // R1: user level and missing features
        clear_ctl(); cur_level = 2'd0; issue();
        clear_ctl(); cur_level = 2'd3; feat_ic_v3 = 1'b0; issue();
        clear_ctl(); cur_level = 2'd2; feat_aa32_kern = 1'b0; issue();
        // R2: early undef beats group-12 trap; skipped in 32-bit monitor mode
        clear_ctl(); cur_level = 2'd1; mon_present = 1'b1; mon_early_undef = 1'b1;
        mon_irq_route_a64 = 1'b1; hyp_enabled = 1'b1; hyp_g12_trap_a64 = 1'b1; issue();
        clear_ctl(); cur_level = 2'd1; mon_present = 1'b1; mon_is_aa32 = 1'b1;
        in_mon_mode = 1'b1; mon_early_undef = 1'b1; mon_irq_route_a32 = 1'b1; issue();
        // R3: 32-bit hypervisor form group-12 trap beats enable bit 0
        clear_ctl(); cur_level = 2'd1; hyp_enabled = 1'b1; hyp_is_aa32 = 1'b1;
        hyp_g12_trap_a32 = 1'b1; sre_kern = 1'b0; issue();
        // R4: enable bit 0 beats trap-all-Group-1
        clear_ctl(); cur_level = 2'd1; hyp_enabled = 1'b1; hyp_trap_grp1_a64 = 1'b1;
        sre_kern = 1'b0; issue();
        // R5
        clear_ctl(); cur_level = 2'd1; hyp_enabled = 1'b1; hyp_trap_grp1_a64 = 1'b1;
        hyp_virq_a64 = 1'b1; issue();
        // R6 with narrow IDs and with no observable interrupt (R10, R11)
        clear_ctl(); cur_level = 2'd1; hyp_enabled = 1'b1; hyp_virq_a64 = 1'b1;
        mon_present = 1'b1; mon_irq_route_a64 = 1'b1; id_wide = 1'b0; issue();
        clear_ctl(); cur_level = 2'd1; hyp_enabled = 1'b1; hyp_virq_a64 = 1'b1;
        virt_pend_vld = 1'b0; issue();
        // R6 bits ignored when hypervisor disabled -> R7 physical read
        clear_ctl(); cur_level = 2'd1; hyp_virq_a64 = 1'b1; hyp_virq_a32 = 1'b1; issue();
        // R7: monitor trap and monitor undef option
        clear_ctl(); cur_level = 2'd1; mon_present = 1'b1; mon_irq_route_a64 = 1'b1; issue();
        clear_ctl(); cur_level = 2'd1; mon_present = 1'b1; mon_irq_route_a64 = 1'b1;
        mon_undef_sel = 1'b1; issue();
        // R8: hypervisor level, monitor mode exception does not apply
        clear_ctl(); cur_level = 2'd2; mon_present = 1'b1; mon_is_aa32 = 1'b1;
        in_mon_mode = 1'b1; mon_irq_route_a32 = 1'b1; issue();
        clear_ctl(); cur_level = 2'd2; sre_hyp = 1'b0; issue();
        clear_ctl(); cur_level = 2'd2; phys_pend_vld = 1'b0; id_wide = 1'b0; issue();
        // R9
        clear_ctl(); cur_level = 2'd3; sre_mon = 1'b0; issue();
        clear_ctl(); cur_level = 2'd3; issue();
        // R12/R13: no request
        clear_ctl(); cur_level = 2'd3; req = 1'b0; issue();

        for (int n = 0; n < N_RANDOM; n++) begin
            int unsigned r, r2;
            r  = next_rand();
            r2 = next_rand();
            req               = (r[31:29] != 3'b000);
            cur_level         = r[1:0];
            feat_aa32_kern    = (r[4:2] != 3'b000);
            feat_ic_v3        = (r[7:5] != 3'b000);
            hyp_enabled       = r[8];
            hyp_is_aa32       = r[9];
            mon_present       = r[10];
            mon_is_aa32       = r[11];
            in_mon_mode       = r[12];
            mon_early_undef   = r[13];
            mon_undef_sel     = r[14];
            mon_irq_route_a64 = r[15];
            mon_irq_route_a32 = r[16];
            hyp_g12_trap_a64  = r[17] & r[18];
            hyp_g12_trap_a32  = r[19] & r[18];
            hyp_trap_grp1_a64 = r[20];
            hyp_trap_grp1_a32 = r[21];
            hyp_virq_a64      = r[22];
            hyp_virq_a32      = r[23];
            sre_kern          = r[24] | r[25];
            sre_hyp           = r[26] | r[27];
            sre_mon           = r[28] | r[25];
            id_wide           = r2[0];
            virt_pend_vld     = r2[1] | r2[2];
            phys_pend_vld     = r2[3] | r2[2];
            virt_pend_id      = r2[31:8];
            phys_pend_id      = {r2[15:8], r2[31:16]};
            issue();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule